// File: doc/BRIEF.md
# Windowed Address Decoder

This block steers transaction addresses to one of several downstream targets. Software programs up to sixteen address windows through a small 32-bit register port. Each window has a slot of four registers: control (enable and a 4-bit target number), security attributes, a lower bound and an upper bound. Both bounds are kept at 1 MB granularity.

A requester presents an address and a request strobe. One clock later the block reports whether an enabled window covered that address. It also reports which window won, the window's target number and its four security attribute bits. When windows overlap, the lowest-numbered one is chosen. When nothing matches, a miss flag is raised and all result fields read zero.

Window 0 is special. It is the configuration-space window. It is always enabled, always spans 16 MB from its programmed base, and ignores its upper-bound register. Software can move it at run time by rewriting its lower bound.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, windows 1 to 15 are disabled with zero security bits. Window 0 is enabled with base 0 and target 0, so address 0 hits window 0 and address 0x0100_0000 misses.
- R2: Window n occupies register byte offsets n*0x20 to n*0x20+0xC: control at +0x0, security at +0x4, lower bound at +0x8, upper bound at +0xC. Bits that are not implemented read as zero. Offsets +0x10 to +0x1C of a slot read as zero and ignore writes. Read data appears on the cycle after the read strobe.
- R3: In the control register, bit 0 enables the window and bits 11:8 hold the target number.
- R4: Window n (n at least 1) matches when it is enabled and address bits 47:20 lie between lower-bound bits 31:4 and upper-bound bits 31:4, both bounds included.
- R5: Window 0 matches addresses from (lower-bound bits 31:4) shifted left by 20, up to but not including that value plus 16 MB. Its upper-bound register has no effect on matching.
- R6: Window 0 cannot be disabled. Writing 0 to its enable bit has no effect on lookups, and its enable bit always reads as 1.
- R7: Rewriting the lower bound of window 0 relocates it: the old range stops matching and the new range starts matching.
- R8: When several enabled windows match, the result reports the lowest-numbered one.
- R9: On a lookup that matches no window, the miss output is 1, the hit output is 0, and the window number, target number and security bits are all 0.
- R10: A request sampled on a clock edge produces its result on that edge. The valid output is high for exactly one cycle per request and is low when no request was made.
- R11: A register write applies to lookups sampled on later edges. A lookup sampled on the same edge as the write still sees the old contents.
- R12: The security output carries bits 3:0 of the matching window's security register: bit 0 control-write-secure, bit 1 control-read-secure, bit 2 write-secure, bit 3 read-secure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd_en |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Lookup address |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An enabled window matched |
| lk_miss | output | 1 | No window matched |
| lk_win | output | 4 | Winning window number |
| lk_tid | output | 4 | Target number of the winning window |
| lk_sec | output | 4 | Security bits of the winning window |

## Verification
A lookup result and a read result each appear one edge after their strobe is sampled. A register write changes what lookups see starting from the next sampled edge. The bench drives strobes on falling edges and checks on the following falling edge, which is the first point where the result registers hold the answer. For the write-versus-lookup ordering (R11), a write and a lookup are driven in the same cycle. The bench expects the old mapping on that first result and the new mapping on the lookup that follows.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int AW     = 48;          // lookup address width
    localparam int GRAN   = 20;          // 1 MB granule shift
    localparam int FLD_W  = AW - GRAN;   // stored bound bits
    localparam int TID_W  = 4;
    localparam int SEC_W  = 4;
    localparam int DW     = 32;
    localparam int SLOT_SH = 5;          // 0x20 bytes per window slot

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_SEC  = 2'd1,
        FLD_LO   = 2'd2,
        FLD_HI   = 2'd3
    } fld_e;

    typedef enum logic [TID_W-1:0] {
        TGT_CFG    = 4'd0,
        TGT_LINK_A = 4'd1,
        TGT_PCIE_B = 4'd2,
        TGT_PCIE_C = 4'd3,
        TGT_PCIE_A = 4'd4,
        TGT_FLASH  = 4'd5,
        TGT_REGS   = 4'd6,
        TGT_LINK_B = 4'd7
    } target_e;

    typedef struct packed {
        logic             en;
        logic [TID_W-1:0] tid;
        logic [SEC_W-1:0] sec;
        logic [FLD_W-1:0] lo;
        logic [FLD_W-1:0] hi;
    } win_cfg_t;
endpackage

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter bit IS_CFG      = 1'b0,
    parameter int CFG_SPAN_SH = 4
) (
    input  logic             en,
    input  logic [FLD_W-1:0] lo,
    input  logic [FLD_W-1:0] hi,
    input  logic [FLD_W-1:0] granule,
    output logic             hit
);
    generate
        if (IS_CFG) begin : g_cfg
            logic [FLD_W-1:0] offset;
            logic             unused_fields;
            assign unused_fields = en ^ (^hi);
            assign offset = granule - lo;
            assign hit = (granule >= lo) && ((offset >> CFG_SPAN_SH) == '0);
        end else begin : g_range
            assign hit = en && (granule >= lo) && (granule <= hi);
        end
    endgenerate
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
    parameter int NUM_WIN = 16,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] hits,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 16,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int RAW    = IDX_W + SLOT_SH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [RAW-1:0]              addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output win_cfg_t [NUM_WIN-1:0]      cfg
);
    typedef struct packed {
        win_cfg_t [NUM_WIN-1:0] win;
        logic [DW-1:0]          rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [IDX_W-1:0] sel;
    fld_e             fld;
    logic             slot_ok;
    logic             unused_addr;

    assign sel         = addr[RAW-1:SLOT_SH];
    assign fld         = fld_e'(addr[3:2]);
    assign slot_ok     = !addr[4] && ({1'b0, sel} < (IDX_W+1)'(NUM_WIN));
    assign unused_addr = ^addr[1:0];

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        if (wr_en && slot_ok) begin
            case (fld)
                FLD_CTRL: begin
                    st_d.win[sel].en  = wdata[0];
                    st_d.win[sel].tid = wdata[11:8];
                end
                FLD_SEC: st_d.win[sel].sec = wdata[SEC_W-1:0];
                FLD_LO:  st_d.win[sel].lo  = wdata[DW-1:4];
                default: st_d.win[sel].hi  = wdata[DW-1:4];
            endcase
        end
        st_d.win[0].en = 1'b1;
        if (rd_en && slot_ok) begin
            case (fld)
                FLD_CTRL: st_d.rdata = {20'b0, st_q.win[sel].tid, 7'b0, st_q.win[sel].en};
                FLD_SEC:  st_d.rdata = {{(DW-SEC_W){1'b0}}, st_q.win[sel].sec};
                FLD_LO:   st_d.rdata = {st_q.win[sel].lo, 4'b0};
                default:  st_d.rdata = {st_q.win[sel].hi, 4'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.win[0].en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg   = st_q.win;
    assign rdata = st_q.rdata;
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN     = 16,
    parameter int CFG_SPAN_SH = 4,
    localparam int IDX_W      = $clog2(NUM_WIN),
    localparam int RAW        = IDX_W + SLOT_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_rd_en,
    input  logic [RAW-1:0]   reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             lk_req,
    input  logic [AW-1:0]    lk_addr,
    output logic             lk_valid,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [IDX_W-1:0] lk_win,
    output logic [TID_W-1:0] lk_tid,
    output logic [SEC_W-1:0] lk_sec
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [IDX_W-1:0] win;
        logic [TID_W-1:0] tid;
        logic [SEC_W-1:0] sec;
    } lk_state_t;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     hits;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [FLD_W-1:0]       granule;
    logic                   unused_low;
    lk_state_t              res_d, res_q;

    assign granule    = lk_addr[AW-1:GRAN];
    assign unused_low = ^lk_addr[GRAN-1:0];

    awd_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .rd_en (reg_rd_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        awd_match #(
            .IS_CFG      (w == 0),
            .CFG_SPAN_SH (CFG_SPAN_SH)
        ) u_match (
            .en      (cfg[w].en),
            .lo      (cfg[w].lo),
            .hi      (cfg[w].hi),
            .granule (granule),
            .hit     (hits[w])
        );
    end

    awd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .hits (hits),
        .any  (any_hit),
        .idx  (win_idx)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_req;
        if (lk_req) begin
            if (any_hit) begin
                res_d.hit = 1'b1;
                res_d.win = win_idx;
                res_d.tid = cfg[win_idx].tid;
                res_d.sec = cfg[win_idx].sec;
            end else begin
                res_d.miss = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign lk_valid = res_q.valid;
    assign lk_hit   = res_q.hit;
    assign lk_miss  = res_q.miss;
    assign lk_win   = res_q.win;
    assign lk_tid   = res_q.tid;
    assign lk_sec   = res_q.sec;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
    parameter int IDX_W = 4,
    parameter int RAW   = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_rd_en,
    input logic [RAW-1:0]   reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             lk_req,
    input logic             lk_valid,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [IDX_W-1:0] lk_win,
    input logic [3:0]       lk_tid,
    input logic [3:0]       lk_sec
);
    assert_req_gives_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    assert_no_req_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid);

    assert_hit_or_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_win == '0 && lk_tid == '0 && lk_sec == '0));

    assert_cfg_win_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == '0) |=> reg_rdata[0]);

    assert_sec_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr[4:0] == 5'h04) |=> (reg_rdata[31:4] == '0));
endmodule

bind addr_window_decoder awd_checker #(.IDX_W(IDX_W), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lk_req    (lk_req),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_win    (lk_win),
    .lk_tid    (lk_tid),
    .lk_sec    (lk_sec)
);

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_req = 1'b0;
    logic [47:0] lk_addr = '0;
    logic        lk_valid, lk_hit, lk_miss;
    logic [3:0]  lk_win, lk_tid, lk_sec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addr_window_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
        .lk_win(lk_win), .lk_tid(lk_tid), .lk_sec(lk_sec)
    );

    function automatic logic [8:0] ra(input int win, input int fld);
        return 9'(win * 32 + fld * 4);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int win, input int fld, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = ra(win, fld); reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int win, input int fld,
                            input logic [31:0] exp);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = ra(win, fld);
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk(req, "read data", reg_rdata, exp);
    endtask

    // issues a lookup and checks the result one edge later
    task automatic lk_check(input string req, input logic [47:0] a, input bit exp_hit,
                            input int exp_win, input int exp_tid, input int exp_sec);
        @(negedge clk);
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
        chk(req, "valid", lk_valid, 1);
        chk(req, "hit",   lk_hit,  exp_hit);
        chk(req, "miss",  lk_miss, !exp_hit);
        chk(req, "win",   lk_win,  exp_win);
        chk(req, "tid",   lk_tid,  exp_tid);
        chk(req, "sec",   lk_sec,  exp_sec);
    endtask

    task automatic t_reset;
        chk("R1", "rdata after reset", reg_rdata, 0);
        chk("R10", "valid after reset", lk_valid, 0);
        lk_check("R1", 48'h0, 1, 0, 0, 0);
        lk_check("R1", 48'h0_00FF_FFFF, 1, 0, 0, 0);
        lk_check("R1", 48'h0_0100_0000, 0, 0, 0, 0);
        lk_check("R1", 48'h1_0000_0000, 0, 0, 0, 0);
        rd_check("R1", 0, 0, 32'h0000_0001);
        rd_check("R1", 7, 1, 32'h0);
        rd_check("R1", 15, 0, 32'h0);
    endtask

    task automatic t_regmap;
        wr(2, 2, 32'h0000_1234);
        rd_check("R2", 2, 2, 32'h0000_1230);
        wr(2, 3, 32'hFFFF_FFFF);
        rd_check("R2", 2, 3, 32'hFFFF_FFF0);
        wr(2, 1, 32'h0000_00FF);
        rd_check("R2", 2, 1, 32'h0000_000F);
        wr(2, 0, 32'hFFFF_FFFF);
        rd_check("R3", 2, 0, 32'h0000_0F01);
        wr(2, 4, 32'hFFFF_FFFF);
        rd_check("R2", 2, 4, 32'h0);
        rd_check("R2", 3, 2, 32'h0);
        wr(2, 0, 32'h0);
        rd_check("R3", 2, 0, 32'h0);
    endtask

    task automatic t_range;
        wr(1, 2, 32'h0001_0000);   // granule 0x1000 -> 4 GB
        wr(1, 3, 32'h0001_0030);   // granule 0x1003
        wr(1, 1, 32'h0000_0005);
        lk_check("R4", 48'h1_0000_0000, 0, 0, 0, 0); // not yet enabled
        wr(1, 0, 32'h0000_0201);
        lk_check("R4", 48'h1_0000_0000, 1, 1, 2, 5);
        lk_check("R12", 48'h1_003F_FFFF, 1, 1, 2, 5);
        lk_check("R4", 48'h1_0040_0000, 0, 0, 0, 0);
        lk_check("R9", 48'h0_FFFF_FFFF, 0, 0, 0, 0);
        wr(1, 1, 32'h0000_000A);
        lk_check("R12", 48'h1_0020_0000, 1, 1, 2, 10);
    endtask

    task automatic t_cfg_window;
        wr(0, 2, 32'h0000_8000);   // move to 0x8000_0000
        lk_check("R7", 48'h0_8000_0000, 1, 0, 0, 0);
        lk_check("R7", 48'h0, 0, 0, 0, 0);
        lk_check("R5", 48'h0_80FF_FFFF, 1, 0, 0, 0);
        lk_check("R5", 48'h0_8100_0000, 0, 0, 0, 0);
        lk_check("R5", 48'h0_7FFF_FFFF, 0, 0, 0, 0);
        wr(0, 3, 32'hFFFF_FFF0);
        lk_check("R5", 48'h0_8100_0000, 0, 0, 0, 0);
        wr(0, 3, 32'h0);
        lk_check("R5", 48'h0_80FF_FFFF, 1, 0, 0, 0);
        wr(0, 0, 32'h0000_0600);
        lk_check("R6", 48'h0_8040_0000, 1, 0, 6, 0);
        rd_check("R6", 0, 0, 32'h0000_0601);
    endtask

    task automatic t_priority;
        wr(5, 2, 32'h0002_0000); wr(5, 3, 32'h0002_0000); wr(5, 1, 32'h3);
        wr(9, 2, 32'h0002_0000); wr(9, 3, 32'h0002_0000); wr(9, 1, 32'hC);
        wr(9, 0, 32'h0000_0701);
        lk_check("R8", 48'h2_0000_0000, 1, 9, 7, 12);
        wr(5, 0, 32'h0000_0401);
        lk_check("R8", 48'h2_000F_FFFF, 1, 5, 4, 3);
        lk_check("R4", 48'h2_0010_0000, 0, 0, 0, 0);
        wr(5, 0, 32'h0);
        lk_check("R8", 48'h2_0000_0000, 1, 9, 7, 12);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = ra(5, 0); reg_wdata = 32'h0000_0401;
        lk_req = 1'b1; lk_addr = 48'h2_0000_0000;
        @(negedge clk);
        reg_wr_en = 1'b0; lk_req = 1'b0;
        chk("R11", "old mapping win", lk_win, 9);
        chk("R11", "old mapping tid", lk_tid, 7);
        lk_check("R11", 48'h2_0000_0000, 1, 5, 4, 3);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "valid idle", lk_valid, 0);
        chk("R10", "hit idle", lk_hit, 0);
        chk("R10", "miss idle", lk_miss, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_range();
        t_cfg_window();
        t_priority();
        t_same_cycle();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule